// File: doc/BRIEF.md
# Floating-point Instruction Access Checker

This block sits beside the decode stage of a core that has a floating-point and SIMD unit. For every instruction of that unit that decode presents to it, the block returns one verdict a clock later. The instruction may execute, it must be treated as undefined, its result is unpredictable, or it is an implementation-defined move to a system register index that the unit does not define. The inputs are the class of the instruction, the system-register index it targets, whether it is a SIMD instruction, the current privilege and security state, and the live contents of three control registers. Those registers are a non-secure access register with one bit per FP coprocessor number, a coprocessor access register with a two-bit field per FP coprocessor number and a SIMD-disable bit, and the unit's global enable bit.

The checks form a fixed ladder, and the first rung that fails decides the verdict. The security checks come first, then the two-bit access field, then SIMD-disable, then the system-register index, and last the global enable. While the unit is disabled, a short list of privileged system-register moves still gets through, so that software can inspect the unit and turn it back on. A parameter removes the security rung for cores that have no secure/non-secure split.

Top module: `fpu_gate_check`

## Requirements
- R1: Each cycle with `req_valid` high produces, on the next clock, `rsp_valid` high with exactly one of `rsp_allow`, `rsp_undef`, `rsp_unpred`, `rsp_impl` high. A cycle without a request gives all five outputs low on the next clock. A synchronous reset (`rst_n` low at a clock edge) clears all five outputs.
- R2: With `SEC_EXT`=1, a request for which `nsac_cp_a` differs from `nsac_cp_b` is unpredictable.
- R3: With `SEC_EXT`=1, equal non-secure bits, `cur_nonsec`=1 and `nsac_cp_a`=0, the request is undefined.
- R4: A request for which `cpac_a` differs from `cpac_b` is unpredictable.
- R5: When the fields are equal, `cpac_a` decides. 2'b00 gives undefined. 2'b01 gives undefined when `cur_priv`=0 and passes when `cur_priv`=1. 2'b10 gives unpredictable. 2'b11 passes.
- R6: A request with `req_simd`=1 while `cpac_simd_off`=1 is undefined.
- R7: `req_cls` 2'b01 is a write to a system register and 2'b10 is a read from one. For these, an index other than 0 (ID), 1 (status/control), 6 and 7 (media features) or 8 (exception/enable) reports `rsp_impl`.
- R8: With `fpen`=0, data operations (`req_cls` 2'b00, or 2'b11, which is handled as a data operation) are undefined. Reads and writes of index 1 are also undefined.
- R9: With `fpen`=0, a write to index 8 or 0, or a read of index 8, 0, 6 or 7, is allowed when `cur_priv`=1 and undefined when `cur_priv`=0. Any other defined move is undefined.
- R10: A request that fails no check is allowed.
- R11: With `SEC_EXT`=0, `cur_nonsec`, `nsac_cp_a` and `nsac_cp_b` have no effect on the verdict.
- R12: The checks apply in the order R2, R3, R4, R5, R6, R7, R8/R9, and the first that fails gives the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_cls | input | 2 | Instruction class: 00 data, 01 write to system register, 10 read from system register, 11 data |
| req_idx | input | IDX_W | System-register index for moves |
| req_simd | input | 1 | Instruction is a SIMD instruction |
| cur_priv | input | 1 | Current mode is privileged |
| cur_nonsec | input | 1 | Processor is in non-secure state |
| nsac_cp_a | input | 1 | Non-secure access bit, first FP coprocessor number |
| nsac_cp_b | input | 1 | Non-secure access bit, second FP coprocessor number |
| cpac_a | input | 2 | Access field, first FP coprocessor number |
| cpac_b | input | 2 | Access field, second FP coprocessor number |
| cpac_simd_off | input | 1 | SIMD-disable bit |
| fpen | input | 1 | Global FP enable bit |
| rsp_valid | output | 1 | Verdict strobe |
| rsp_allow | output | 1 | Instruction may execute |
| rsp_undef | output | 1 | Instruction is undefined |
| rsp_unpred | output | 1 | Result is unpredictable |
| rsp_impl | output | 1 | Move targets an index the unit does not define |

## Verification
Several properties are checked on every cycle:
- the one-hot verdict and its one-cycle timing;
- the non-secure mismatch and non-secure block outcomes;
- access-field disagreement when security passes;
- that no user-mode request and no status/control move is allowed while the unit is disabled;
- that no SIMD request is allowed while SIMD is disabled.

Other behaviours can only be shown by the bench's scenarios:
- the full two-bit field decode;
- the whitelist of moves that survive a disabled unit;
- the implementation-defined index outcome;
- the exact priority between competing failures;
- the insensitivity of the variant without the security rung to its non-secure inputs.

The bench covers these with an exhaustive sweep of the control inputs and with directed cases, run on both variants side by side.

// File: rtl/fpu_gate_pkg.sv
package fpu_gate_pkg;

   // verdict from one rung of the check ladder
   typedef enum logic [1:0] {
      VD_PASS   = 2'd0,
      VD_UNDEF  = 2'd1,
      VD_UNPRED = 2'd2,
      VD_IMPL   = 2'd3
   } verdict_t;

   // instruction classes as presented by decode
   localparam logic [1:0] CLS_DATA = 2'b00;
   localparam logic [1:0] CLS_WR   = 2'b01;
   localparam logic [1:0] CLS_RD   = 2'b10;
   localparam logic [1:0] CLS_ALT  = 2'b11;

   // two-bit access field codes
   localparam logic [1:0] ACC_NONE = 2'b00;
   localparam logic [1:0] ACC_PRIV = 2'b01;
   localparam logic [1:0] ACC_RSVD = 2'b10;
   localparam logic [1:0] ACC_FULL = 2'b11;

   // defined system-register indices
   localparam int unsigned REG_ID  = 0;
   localparam int unsigned REG_CTL = 1;
   localparam int unsigned REG_MF1 = 6;
   localparam int unsigned REG_MF0 = 7;
   localparam int unsigned REG_EXC = 8;

   // ladder rungs, lowest index has highest priority
   localparam int unsigned STG_SEC  = 0;
   localparam int unsigned STG_ACC  = 1;
   localparam int unsigned STG_SIMD = 2;
   localparam int unsigned STG_REG  = 3;
   localparam int unsigned STG_EN   = 4;
   localparam int unsigned NUM_STG  = 5;

endpackage

// File: rtl/fpu_gate_sec.sv
module fpu_gate_sec
   import fpu_gate_pkg::*;
#(
   parameter bit SEC_EXT = 1'b1
) (
   input  logic     nonsec,
   input  logic     ns_a,
   input  logic     ns_b,
   output verdict_t vd
);

   generate
      if (SEC_EXT) begin : g_sec
         always_comb begin
            if (ns_a != ns_b)
               vd = VD_UNPRED;
            else if (nonsec && !ns_a)
               vd = VD_UNDEF;
            else
               vd = VD_PASS;
         end
      end else begin : g_nosec
         logic unused_ns;
         assign unused_ns = ^{nonsec, ns_a, ns_b};
         assign vd = VD_PASS;
      end
   endgenerate

endmodule

// File: rtl/fpu_gate_perm.sv
module fpu_gate_perm
   import fpu_gate_pkg::*;
(
   input  logic       priv,
   input  logic [1:0] acc_a,
   input  logic [1:0] acc_b,
   input  logic       simd,
   input  logic       simd_off,
   output verdict_t   vd_acc,
   output verdict_t   vd_simd
);

   always_comb begin
      if (acc_a != acc_b) begin
         vd_acc = VD_UNPRED;
      end else begin
         unique case (acc_a)
            ACC_NONE: vd_acc = VD_UNDEF;
            ACC_PRIV: vd_acc = priv ? VD_PASS : VD_UNDEF;
            ACC_RSVD: vd_acc = VD_UNPRED;
            default:  vd_acc = VD_PASS;
         endcase
      end
   end

   assign vd_simd = (simd && simd_off) ? VD_UNDEF : VD_PASS;

endmodule

// File: rtl/fpu_gate_enable.sv
module fpu_gate_enable
   import fpu_gate_pkg::*;
#(
   parameter int unsigned IDX_W = 4
) (
   input  logic [1:0]       cls,
   input  logic [IDX_W-1:0] idx,
   input  logic             priv,
   input  logic             fp_en,
   output verdict_t         vd_reg,
   output verdict_t         vd_en
);

   logic is_wr, is_rd, is_move;
   logic hit_id, hit_ctl, hit_mf, hit_exc;
   logic known, exempt;

   assign is_wr   = (cls == CLS_WR);
   assign is_rd   = (cls == CLS_RD);
   assign is_move = is_wr || is_rd;

   assign hit_id  = (idx == IDX_W'(REG_ID));
   assign hit_ctl = (idx == IDX_W'(REG_CTL));
   assign hit_mf  = (idx == IDX_W'(REG_MF0)) || (idx == IDX_W'(REG_MF1));
   assign hit_exc = (idx == IDX_W'(REG_EXC));
   assign known   = hit_id || hit_ctl || hit_mf || hit_exc;

   // moves that survive a disabled unit
   assign exempt = (is_wr && (hit_exc || hit_id)) ||
                   (is_rd && (hit_exc || hit_id || hit_mf));

   assign vd_reg = (is_move && !known) ? VD_IMPL : VD_PASS;

   always_comb begin
      if (fp_en)
         vd_en = VD_PASS;
      else if (exempt && priv)
         vd_en = VD_PASS;
      else
         vd_en = VD_UNDEF;
   end

endmodule

// File: rtl/fpu_gate_check.sv
module fpu_gate_check
   import fpu_gate_pkg::*;
#(
   parameter bit          SEC_EXT = 1'b1,
   parameter int unsigned IDX_W   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [1:0]       req_cls,
   input  logic [IDX_W-1:0] req_idx,
   input  logic             req_simd,
   input  logic             cur_priv,
   input  logic             cur_nonsec,
   input  logic             nsac_cp_a,
   input  logic             nsac_cp_b,
   input  logic [1:0]       cpac_a,
   input  logic [1:0]       cpac_b,
   input  logic             cpac_simd_off,
   input  logic             fpen,
   output logic             rsp_valid,
   output logic             rsp_allow,
   output logic             rsp_undef,
   output logic             rsp_unpred,
   output logic             rsp_impl
);

   localparam int unsigned MIN_IDX_W = 4;

   generate
      if (IDX_W < MIN_IDX_W) begin : g_bad_idx
         $error("fpu_gate_check: IDX_W must hold index %0d", REG_EXC);
      end
   endgenerate

   verdict_t stage_vd [NUM_STG];
   verdict_t pick;

   fpu_gate_sec #(
      .SEC_EXT (SEC_EXT)
   ) u_sec (
      .nonsec (cur_nonsec),
      .ns_a   (nsac_cp_a),
      .ns_b   (nsac_cp_b),
      .vd     (stage_vd[STG_SEC])
   );

   fpu_gate_perm u_perm (
      .priv     (cur_priv),
      .acc_a    (cpac_a),
      .acc_b    (cpac_b),
      .simd     (req_simd),
      .simd_off (cpac_simd_off),
      .vd_acc   (stage_vd[STG_ACC]),
      .vd_simd  (stage_vd[STG_SIMD])
   );

   fpu_gate_enable #(
      .IDX_W (IDX_W)
   ) u_en (
      .cls    (req_cls),
      .idx    (req_idx),
      .priv   (cur_priv),
      .fp_en  (fpen),
      .vd_reg (stage_vd[STG_REG]),
      .vd_en  (stage_vd[STG_EN])
   );

   // first failing rung wins
   always_comb begin
      pick = VD_PASS;
      for (int i = NUM_STG - 1; i >= 0; i--) begin
         if (stage_vd[i] != VD_PASS)
            pick = stage_vd[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_allow  <= 1'b0;
         rsp_undef  <= 1'b0;
         rsp_unpred <= 1'b0;
         rsp_impl   <= 1'b0;
      end else begin
         rsp_valid  <= req_valid;
         rsp_allow  <= req_valid && (pick == VD_PASS);
         rsp_undef  <= req_valid && (pick == VD_UNDEF);
         rsp_unpred <= req_valid && (pick == VD_UNPRED);
         rsp_impl   <= req_valid && (pick == VD_IMPL);
      end
   end

endmodule

// File: rtl/fpu_gate_check_sva.sv
module fpu_gate_check_sva #(
   parameter bit          SEC_EXT = 1'b1,
   parameter int unsigned IDX_W   = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic [1:0]       req_cls,
   input logic [IDX_W-1:0] req_idx,
   input logic             req_simd,
   input logic             cur_priv,
   input logic             cur_nonsec,
   input logic             nsac_cp_a,
   input logic             nsac_cp_b,
   input logic [1:0]       cpac_a,
   input logic [1:0]       cpac_b,
   input logic             cpac_simd_off,
   input logic             fpen,
   input logic             rsp_valid,
   input logic             rsp_allow,
   input logic             rsp_undef,
   input logic             rsp_unpred,
   input logic             rsp_impl
);

   logic [3:0] flags;
   logic       sec_ok;
   logic       is_move;

   assign flags   = {rsp_allow, rsp_undef, rsp_unpred, rsp_impl};
   assign is_move = (req_cls == 2'b01) || (req_cls == 2'b10);

   generate
      if (SEC_EXT) begin : g_sec
         assign sec_ok = (nsac_cp_a == nsac_cp_b) && !(cur_nonsec && !nsac_cp_a);

         assert_ns_mismatch_R2: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid && (nsac_cp_a != nsac_cp_b) |=> rsp_unpred);

         assert_ns_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid && (nsac_cp_a == nsac_cp_b) && cur_nonsec && !nsac_cp_a |=> rsp_undef);
      end else begin : g_nosec
         assign sec_ok = 1'b1;
      end
   endgenerate

   assert_one_verdict_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $countones(flags) == 1);

   assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> flags == 4'b0000);

   assert_req_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   assert_no_req_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   assert_acc_mismatch_R4: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && sec_ok && (cpac_a != cpac_b) |=> rsp_unpred);

   assert_simd_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_simd && cpac_simd_off |=> !rsp_allow);

   assert_ctl_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !fpen && is_move && (req_idx == IDX_W'(1)) |=> !rsp_allow);

   assert_user_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !fpen && !cur_priv |=> !rsp_allow);

endmodule

bind fpu_gate_check fpu_gate_check_sva #(
   .SEC_EXT (SEC_EXT),
   .IDX_W   (IDX_W)
) u_sva (.*);

// File: tb/fpu_gate_check_test.sv
module fpu_gate_check_test;

   localparam int unsigned IDX_W = 4;
   localparam int unsigned WATCHDOG_CYC = 190000;

   logic clk = 1'b0;
   logic rst_n;
   logic req_valid;
   logic [1:0] req_cls;
   logic [IDX_W-1:0] req_idx;
   logic req_simd, cur_priv, cur_nonsec, nsac_cp_a, nsac_cp_b;
   logic [1:0] cpac_a, cpac_b;
   logic cpac_simd_off, fpen;

   logic a_valid, a_allow, a_undef, a_unpred, a_impl;
   logic b_valid, b_allow, b_undef, b_unpred, b_impl;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   string tag_ov = "";

   typedef struct {
      logic [4:0] exp_a;
      logic [4:0] exp_b;
      string      tag_a;
      string      tag_b;
   } exp_t;

   exp_t exp_q[$];

   always #10 clk = ~clk;

   fpu_gate_check #(.SEC_EXT(1'b1), .IDX_W(IDX_W)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cls(req_cls),
      .req_idx(req_idx), .req_simd(req_simd), .cur_priv(cur_priv),
      .cur_nonsec(cur_nonsec), .nsac_cp_a(nsac_cp_a), .nsac_cp_b(nsac_cp_b),
      .cpac_a(cpac_a), .cpac_b(cpac_b), .cpac_simd_off(cpac_simd_off),
      .fpen(fpen), .rsp_valid(a_valid), .rsp_allow(a_allow),
      .rsp_undef(a_undef), .rsp_unpred(a_unpred), .rsp_impl(a_impl));

   fpu_gate_check #(.SEC_EXT(1'b0), .IDX_W(IDX_W)) uut_nosec (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cls(req_cls),
      .req_idx(req_idx), .req_simd(req_simd), .cur_priv(cur_priv),
      .cur_nonsec(cur_nonsec), .nsac_cp_a(nsac_cp_a), .nsac_cp_b(nsac_cp_b),
      .cpac_a(cpac_a), .cpac_b(cpac_b), .cpac_simd_off(cpac_simd_off),
      .fpen(fpen), .rsp_valid(b_valid), .rsp_allow(b_allow),
      .rsp_undef(b_undef), .rsp_unpred(b_unpred), .rsp_impl(b_impl));

   // verdict model: returns {allow, undef, unpred, impl} and the deciding rule
   function automatic logic [3:0] model(bit sec, output string tag);
      int ix = int'(req_idx);
      bit mv = (req_cls == 2'b01) || (req_cls == 2'b10);
      bit free;
      if (sec && (nsac_cp_a != nsac_cp_b)) begin tag = "R2"; return 4'b0010; end
      if (sec && cur_nonsec && !nsac_cp_a) begin tag = "R3"; return 4'b0100; end
      if (cpac_a != cpac_b) begin tag = "R4"; return 4'b0010; end
      tag = "R5";
      if (cpac_a == 2'b00) return 4'b0100;
      if (cpac_a == 2'b01 && !cur_priv) return 4'b0100;
      if (cpac_a == 2'b10) return 4'b0010;
      if (req_simd && cpac_simd_off) begin tag = "R6"; return 4'b0100; end
      if (mv && !(ix inside {0, 1, 6, 7, 8})) begin tag = "R7"; return 4'b0001; end
      if (!fpen) begin
         free = (req_cls == 2'b01 && (ix == 8 || ix == 0)) ||
                (req_cls == 2'b10 && (ix inside {0, 6, 7, 8}));
         if (free) begin tag = "R9"; return cur_priv ? 4'b1000 : 4'b0100; end
         tag = "R8";
         return 4'b0100;
      end
      tag = "R10";
      return 4'b1000;
   endfunction

   always @(posedge clk) begin
      exp_t e;
      string ta, tb;
      logic [3:0] va, vb;
      if (!rst_n || !req_valid) begin
         e.exp_a = 5'b0; e.exp_b = 5'b0; e.tag_a = "R1"; e.tag_b = "R1";
      end else begin
         va = model(1'b1, ta);
         vb = model(1'b0, tb);
         e.exp_a = {1'b1, va};
         e.exp_b = {1'b1, vb};
         e.tag_a = (tag_ov != "") ? tag_ov : ta;
         e.tag_b = {"R11 ", tb};
      end
      exp_q.push_back(e);
   end

   always @(negedge clk) begin
      exp_t e;
      logic [4:0] got_a, got_b;
      if (exp_q.size() > 0) begin
         e = exp_q.pop_front();
         got_a = {a_valid, a_allow, a_undef, a_unpred, a_impl};
         got_b = {b_valid, b_allow, b_undef, b_unpred, b_impl};
         checks += 2;
         if (got_a !== e.exp_a) begin
            errors++;
            $display("FAIL %s uut got %b expected %b", e.tag_a, got_a, e.exp_a);
         end
         if (got_b !== e.exp_b) begin
            errors++;
            $display("FAIL %s uut_nosec got %b expected %b", e.tag_b, got_b, e.exp_b);
         end
      end
   end

   task automatic send(input logic [1:0] cls, input int ix, input logic simd,
                       input logic priv, input logic ns, input logic na,
                       input logic nb, input logic [1:0] aa, input logic [1:0] ab,
                       input logic soff, input logic en, input string ov);
      req_valid = 1'b1; req_cls = cls; req_idx = IDX_W'(ix); req_simd = simd;
      cur_priv = priv; cur_nonsec = ns; nsac_cp_a = na; nsac_cp_b = nb;
      cpac_a = aa; cpac_b = ab; cpac_simd_off = soff; fpen = en; tag_ov = ov;
      @(negedge clk);
      req_valid = 1'b0;
      tag_ov = "";
   endtask

   initial begin
      int idx_set[6] = '{0, 1, 3, 6, 7, 8};
      rst_n = 1'b0; req_valid = 1'b0; req_cls = 2'b00; req_idx = '0;
      req_simd = 1'b0; cur_priv = 1'b0; cur_nonsec = 1'b0; nsac_cp_a = 1'b0;
      nsac_cp_b = 1'b0; cpac_a = 2'b00; cpac_b = 2'b00; cpac_simd_off = 1'b0;
      fpen = 1'b0;
      // R1: reset state, with a request held during reset
      @(negedge clk);
      req_valid = 1'b1;
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R10 plain allow, R2/R3 security, R12 priority cases
      send(2'b00, 0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'b11, 2'b11, 1'b0, 1'b1, "R10");
      send(2'b00, 0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 1'b1, "R12");
      send(2'b00, 0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b10, 2'b10, 1'b1, 1'b1, "R12");
      send(2'b01, 5, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 2'b11, 1'b0, 1'b0, "R12");
      send(2'b10, 1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 2'b11, 1'b0, 1'b0, "R8");
      send(2'b01, 8, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 2'b11, 1'b0, 1'b0, "R9");
      // idle gap: R1 no verdict without request
      repeat (3) @(negedge clk);

      // exhaustive sweep of controls, tags come from the deciding rule
      for (int c = 0; c < 4; c++)
         for (int k = 0; k < 6; k++)
            for (int s = 0; s < 4; s++)
               for (int n = 0; n < 8; n++)
                  for (int a = 0; a < 16; a++)
                     for (int m = 0; m < 4; m++)
                        send(2'(c), idx_set[k], s[0], s[1], n[0], n[1], n[2],
                             a[1:0], a[3:2], m[0], m[1], "");

      // R1: reset during traffic clears outputs
      req_valid = 1'b1;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      req_valid = 1'b0;
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (WATCHDOG_CYC) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R1 watchdog got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule